// File: doc/BRIEF.md
# Multi-Mode ADC Channel Sequencer

This block decides which of eight analog inputs the converter samples next. It supports three ways of picking the channel. In manual mode software supplies a fixed channel code. In auto mode the block walks a bitmap of enabled channels from low index to high and wraps around. In frame-directed mode the channel code arrives with each serial frame and is used for the conversion after that frame. Any channel marked as a GPIO is never handed to the converter.

Each conversion opportunity is signalled by a one-cycle trigger (`conv_trig`), normally once per serial frame. If no conversion is outstanding and the active mode yields a usable channel, the block raises `conv_req` for one cycle and presents the channel on `conv_chan`. It then waits for a `conv_done` pulse before it accepts another trigger. A registered busy flag reports whether an auto scan is in progress.

Top module: `adc_chan_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `conv_req`, `conv_chan` and `scan_busy` are 0 after that edge.
- R2: A trigger sampled with no outstanding conversion and a usable channel raises `conv_req` for exactly one cycle after that edge. The conversion stays outstanding until `conv_done` is sampled high, and triggers seen in that time are dropped. A `conv_done` with nothing outstanding has no effect.
- R3: Mode code `mode_sel`=00 is manual. The channel is `manual_code[2:0]`. A code with bit 3 set (reserved), or a channel whose `gpio_mask` bit is 1, issues no request.
- R4: Mode code 01 is auto. The eligible set is `scan_mask & ~gpio_mask` (bit i stands for channel i). Each request takes the lowest eligible channel above the one last issued, and wraps to the lowest eligible channel after the highest.
- R5: Auto scanning advances only while `mode_sel`=01 and `scan_run`=1. When either drops, the scan stops. The next scan starts again from the lowest eligible channel.
- R6: `scan_busy` is 1 in the cycle after an edge at which `mode_sel`=01, `scan_run`=1 and the eligible set is non-empty. Otherwise it is 0, including when every enabled channel is a GPIO.
- R7: Mode code 10 is frame-directed. Each trigger in this mode captures the 4-bit `next_code`, and that code selects the channel at the following trigger; the stored code is 0 after reset. A stored code with bit 3 set, or one naming a GPIO channel, issues no request.
- R8: Mode code 11 is reserved and never issues a request.
- R9: `conv_chan` keeps the last issued channel until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 manual, 01 auto, 10 frame-directed, 11 reserved |
| scan_run | input | 1 | Auto scan enable, level sensitive |
| manual_code | input | 4 | Manual channel code; bit 3 set is reserved |
| scan_mask | input | 8 | Channels enabled for auto scan |
| gpio_mask | input | 8 | 1 marks a channel as GPIO |
| next_code | input | 4 | Channel code carried by the current frame |
| conv_trig | input | 1 | Conversion opportunity, one cycle per frame |
| conv_done | input | 1 | Converter finished the outstanding conversion |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel for the request |
| scan_busy | output | 1 | Auto scan in progress |

## Verification
The hardest case to reach is the auto-mode wraparound while the eligible set is being changed. This covers GPIO bits raised on the channel next in line, the scan being stopped in the middle of a walk, and triggers arriving while a conversion is still outstanding. Directed phases set sparse bitmaps and toggle GPIO bits and the run control between triggers. A long random phase then mixes modes, bitmaps, late and spurious `conv_done` pulses, and triggers. A behavioural model written from the requirements is compared on every clock.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC channel sequencer.
// Assumes two-bit mode codes as listed in the brief.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_MANUAL = 2'b00,
        SEQ_AUTO   = 2'b01,
        SEQ_FRAME  = 2'b10,
        SEQ_RSVD   = 2'b11
    } seq_mode_e;
endpackage

// File: rtl/adc_seq_scan_pick.sv
// Finds the next auto-scan channel: the lowest eligible index above the
// last issued one, or the lowest eligible index when there is none above
// it (or no last index yet). Purely combinational.
module adc_seq_scan_pick #(
    parameter int NUM_CH = 8,
    localparam int ID_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic              have_last,
    input  logic [ID_W-1:0]   last_idx,
    output logic              found,
    output logic [ID_W-1:0]   pick
);
    logic [NUM_CH-1:0] above;
    logic [NUM_CH-1:0] search;

    // Mark eligible channels that lie strictly above the last issued one.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_above
        assign above[g] = elig[g] && (!have_last || (ID_W'(g) > last_idx));
    end

    assign search = (|above) ? above : elig;

    // Lowest set bit of the search vector.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (search[i]) begin
                found = 1'b1;
                pick  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/adc_seq_frame_capture.sv
// Holds the channel code carried by the latest frame so that it can steer
// the following conversion. Synchronous active-low reset to code 0.
module adc_seq_frame_capture #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);
    // Store the frame code on each capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (capture) code_q <= code_in;
    end
endmodule

// File: rtl/adc_seq_mode_select.sv
// Chooses the candidate channel and its validity for the active mode.
// Codes carry a reserved MSB; GPIO channels are never valid.
module adc_seq_mode_select
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int ID_W = $clog2(NUM_CH),
    localparam int CODE_W = ID_W + 1
) (
    input  seq_mode_e         mode,
    input  logic [CODE_W-1:0] manual_code,
    input  logic [CODE_W-1:0] frame_code,
    input  logic [NUM_CH-1:0] gpio_mask,
    input  logic              scan_live,
    input  logic              scan_found,
    input  logic [ID_W-1:0]   scan_pick,
    output logic              cand_valid,
    output logic [ID_W-1:0]   cand_chan
);
    logic man_ok;
    logic frm_ok;

    assign man_ok = !manual_code[CODE_W-1] && !gpio_mask[manual_code[ID_W-1:0]];
    assign frm_ok = !frame_code[CODE_W-1] && !gpio_mask[frame_code[ID_W-1:0]];

    // Mode multiplexer for channel and validity.
    always_comb begin
        cand_valid = 1'b0;
        cand_chan  = '0;
        unique case (mode)
            SEQ_MANUAL: begin
                cand_valid = man_ok;
                cand_chan  = manual_code[ID_W-1:0];
            end
            SEQ_AUTO: begin
                cand_valid = scan_live && scan_found;
                cand_chan  = scan_pick;
            end
            SEQ_FRAME: begin
                cand_valid = frm_ok;
                cand_chan  = frame_code[ID_W-1:0];
            end
            default: begin
                cand_valid = 1'b0;
                cand_chan  = '0;
            end
        endcase
    end
endmodule

// File: rtl/adc_chan_sequencer.sv
// Top of the channel sequencer. Turns triggers into one-cycle conversion
// requests, keeps one conversion outstanding until done, tracks the auto
// scan position and reports a registered busy flag.
// Assumes conv_trig and conv_done are synchronous single-cycle pulses.
module adc_chan_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int ID_W = $clog2(NUM_CH),
    localparam int CODE_W = ID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              scan_run,
    input  logic [CODE_W-1:0] manual_code,
    input  logic [NUM_CH-1:0] scan_mask,
    input  logic [NUM_CH-1:0] gpio_mask,
    input  logic [CODE_W-1:0] next_code,
    input  logic              conv_trig,
    input  logic              conv_done,
    output logic              conv_req,
    output logic [ID_W-1:0]   conv_chan,
    output logic              scan_busy
);
    seq_mode_e         mode;
    logic [NUM_CH-1:0] elig;
    logic              scan_live;
    logic              have_last_q;
    logic [ID_W-1:0]   last_q;
    logic              scan_found;
    logic [ID_W-1:0]   scan_pick;
    logic [CODE_W-1:0] frame_code;
    logic              cand_valid;
    logic [ID_W-1:0]   cand_chan;
    logic              pending_q;
    logic              issue;

    assign mode      = seq_mode_e'(mode_sel);
    assign elig      = scan_mask & ~gpio_mask;
    assign scan_live = (mode == SEQ_AUTO) && scan_run && (|elig);
    assign issue     = conv_trig && !pending_q && cand_valid;

    adc_seq_scan_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig      (elig),
        .have_last (have_last_q),
        .last_idx  (last_q),
        .found     (scan_found),
        .pick      (scan_pick)
    );

    adc_seq_frame_capture #(.CODE_W(CODE_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (conv_trig && (mode == SEQ_FRAME)),
        .code_in (next_code),
        .code_q  (frame_code)
    );

    adc_seq_mode_select #(.NUM_CH(NUM_CH)) u_sel (
        .mode        (mode),
        .manual_code (manual_code),
        .frame_code  (frame_code),
        .gpio_mask   (gpio_mask),
        .scan_live   (scan_live),
        .scan_found  (scan_found),
        .scan_pick   (scan_pick),
        .cand_valid  (cand_valid),
        .cand_chan   (cand_chan)
    );

    // Outstanding-conversion flag: set on a request, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending_q <= 1'b0;
        else if (issue)     pending_q <= 1'b1;
        else if (conv_done) pending_q <= 1'b0;
    end

    // Request pulse and held channel output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_req  <= 1'b0;
            conv_chan <= '0;
        end else begin
            conv_req <= issue;
            if (issue) conv_chan <= cand_chan;
        end
    end

    // Auto scan position: restart when not live, advance on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last_q <= 1'b0;
            last_q      <= '0;
        end else if (!scan_live) begin
            have_last_q <= 1'b0;
        end else if (issue) begin
            have_last_q <= 1'b1;
            last_q      <= cand_chan;
        end
    end

    // Registered busy status of the auto scan.
    always_ff @(posedge clk) begin
        if (!rst_n) scan_busy <= 1'b0;
        else        scan_busy <= scan_live;
    end
endmodule

// File: rtl/adc_chan_sequencer_checker.sv
// Property checker for the channel sequencer, attached by bind.
// Keeps one-cycle copies of inputs to relate requests to their cause.
module adc_chan_sequencer_checker #(
    parameter int NUM_CH = 8,
    localparam int ID_W = $clog2(NUM_CH),
    localparam int CODE_W = ID_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              scan_run,
    input logic [CODE_W-1:0] manual_code,
    input logic [NUM_CH-1:0] scan_mask,
    input logic [NUM_CH-1:0] gpio_mask,
    input logic              conv_req,
    input logic [ID_W-1:0]   conv_chan,
    input logic              scan_busy
);
    logic [1:0]        mode_d;
    logic [CODE_W-1:0] code_d;
    logic [NUM_CH-1:0] scan_d;
    logic [NUM_CH-1:0] gpio_d;

    // Delay the inputs by one clock for comparison with registered outputs.
    always_ff @(posedge clk) begin
        mode_d <= mode_sel;
        code_d <= manual_code;
        scan_d <= scan_mask;
        gpio_d <= gpio_mask;
    end

    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    assert_manual_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && mode_d == 2'b00) |->
            (!code_d[CODE_W-1] && conv_chan == code_d[ID_W-1:0] && !gpio_d[conv_chan]));

    assert_auto_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && mode_d == 2'b01) |-> (scan_d[conv_chan] && !gpio_d[conv_chan]));

    assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> ($past(mode_sel) == 2'b01 && $past(scan_run)));

    assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (mode_d != 2'b11));

    assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_req |-> $stable(conv_chan));
endmodule

bind adc_chan_sequencer adc_chan_sequencer_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .scan_run    (scan_run),
    .manual_code (manual_code),
    .scan_mask   (scan_mask),
    .gpio_mask   (gpio_mask),
    .conv_req    (conv_req),
    .conv_chan   (conv_chan),
    .scan_busy   (scan_busy)
);

// File: tb/adc_chan_sequencer_test.sv
// Bench: behavioural reference model compared on every clock.
module adc_chan_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       scan_run = 1'b0;
    logic [3:0] manual_code = 4'd0;
    logic [7:0] scan_mask = 8'd0;
    logic [7:0] gpio_mask = 8'd0;
    logic [3:0] next_code = 4'd0;
    logic       conv_trig = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_req;
    logic [2:0] conv_chan;
    logic       scan_busy;

    always #2 clk = ~clk;

    adc_chan_sequencer uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .scan_run(scan_run),
        .manual_code(manual_code), .scan_mask(scan_mask), .gpio_mask(gpio_mask),
        .next_code(next_code), .conv_trig(conv_trig), .conv_done(conv_done),
        .conv_req(conv_req), .conv_chan(conv_chan), .scan_busy(scan_busy)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    bit done_rand = 0;

    // reference model state
    bit m_out, m_req, m_busy, m_have;
    int m_chan, m_last, m_otf;

    task automatic model_edge();
        bit [7:0] el;
        bit run, nreq;
        int nchan, base, c;
        if (!rst_n) begin
            m_out = 0; m_req = 0; m_busy = 0; m_have = 0;
            m_chan = 0; m_last = 0; m_otf = 0;
            return;
        end
        el = scan_mask & ~gpio_mask;
        run = (mode_sel == 2'b01) && scan_run && (el != 0);
        nreq = 0; nchan = m_chan;
        if (conv_trig && !m_out) begin
            case (mode_sel)
                2'b00: if (manual_code < 8 && !gpio_mask[manual_code[2:0]]) begin
                    nreq = 1; nchan = manual_code;
                end
                2'b01: if (run) begin
                    base = m_have ? m_last : 7;
                    for (int k = 1; k <= 8; k++) begin
                        c = (base + k) % 8;
                        if (!nreq && el[c]) begin nreq = 1; nchan = c; end
                    end
                end
                2'b10: if (m_otf < 8 && !gpio_mask[m_otf]) begin
                    nreq = 1; nchan = m_otf;
                end
                default: ;
            endcase
        end
        if (!run) m_have = 0;
        else if (nreq) begin m_have = 1; m_last = nchan; end
        if (conv_trig && mode_sel == 2'b10) m_otf = next_code;
        if (nreq) m_out = 1;
        else if (conv_done) m_out = 0;
        m_req = nreq; m_chan = nchan; m_busy = run;
    endtask

    // One clock: optional random done, model update at the edge, compare after.
    task automatic step(string tag);
        if (done_rand) conv_done = ($urandom_range(0, 2) == 0);
        @(posedge clk);
        model_edge();
        #1;
        vectors++;
        if (conv_req !== m_req || conv_chan !== 3'(m_chan) || scan_busy !== m_busy) begin
            miscompares++;
            $display("FAIL %s: req/chan/busy actual %b/%0d/%b expected %b/%0d/%b at %0t",
                     tag, conv_req, conv_chan, scan_busy, m_req, m_chan, m_busy, $time);
        end
        @(negedge clk);
    endtask

    // Trigger once, then clear done on the next cycle after model sees it.
    task automatic trig_and_finish(string tag);
        conv_trig = 1; conv_done = 0;
        step(tag);
        conv_trig = 0;
        step(tag);
        conv_done = 1;
        step(tag);
        conv_done = 0;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        repeat (3) step("R1");
        rst_n = 1;
        step("R1");

        // R3: manual mode over every code, no GPIO
        mode_sel = 2'b00;
        for (int i = 0; i < 16; i++) begin
            manual_code = 4'(i);
            trig_and_finish("R3");
        end
        // R3: manual with GPIO channels
        gpio_mask = 8'b0011_0100;
        for (int i = 0; i < 8; i++) begin
            manual_code = 4'(i);
            trig_and_finish("R3");
        end
        // R2: triggers while outstanding are dropped; spurious done ignored
        gpio_mask = 8'd0; manual_code = 4'd6;
        conv_done = 1; step("R2"); conv_done = 0;
        conv_trig = 1;
        repeat (5) step("R2");
        conv_done = 1; step("R2");
        conv_done = 0; repeat (3) step("R2");
        conv_trig = 0; conv_done = 1; step("R2"); conv_done = 0;

        // R4: auto walk with wrap over a sparse bitmap
        mode_sel = 2'b01; scan_mask = 8'b1010_0110; scan_run = 1;
        for (int i = 0; i < 10; i++) trig_and_finish("R4");
        // R4: GPIO on channel 5 removes it from the walk
        gpio_mask = 8'b0010_0000;
        for (int i = 0; i < 6; i++) trig_and_finish("R4");
        // R5: stop mid walk, restart from lowest
        scan_run = 0;
        trig_and_finish("R5");
        scan_run = 1;
        for (int i = 0; i < 4; i++) trig_and_finish("R5");
        mode_sel = 2'b00; step("R5"); mode_sel = 2'b01;
        for (int i = 0; i < 3; i++) trig_and_finish("R5");
        // R6: all enabled channels are GPIO -> idle, busy low
        gpio_mask = scan_mask;
        for (int i = 0; i < 3; i++) trig_and_finish("R6");
        scan_mask = 8'd0; gpio_mask = 8'd0;
        for (int i = 0; i < 2; i++) trig_and_finish("R6");
        scan_mask = 8'b1000_0001;
        for (int i = 0; i < 4; i++) trig_and_finish("R6");

        // R7: frame-directed, code used at following trigger
        mode_sel = 2'b10; scan_run = 0; gpio_mask = 8'b0000_1000;
        for (int i = 0; i < 12; i++) begin
            next_code = 4'((i * 5 + 1) % 16);
            trig_and_finish("R7");
        end
        // R8: reserved mode
        mode_sel = 2'b11;
        for (int i = 0; i < 4; i++) trig_and_finish("R8");
        // R9: conv_chan holds with no request
        mode_sel = 2'b00; repeat (4) step("R9");

        // R2: random mix of all inputs
        done_rand = 1;
        for (int i = 0; i < 4000; i++) begin
            mode_sel    = 2'($urandom_range(0, 3));
            scan_run    = ($urandom_range(0, 3) != 0);
            manual_code = 4'($urandom_range(0, 15));
            next_code   = 4'($urandom_range(0, 15));
            conv_trig   = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 15) == 0) scan_mask = 8'($urandom);
            if ($urandom_range(0, 15) == 0) gpio_mask = 8'($urandom) & 8'($urandom);
            if ($urandom_range(0, 63) == 0) mode_sel = 2'b01;
            step("R2");
        end
        done_rand = 0; conv_trig = 0;
        rst_n = 0; step("R1"); step("R1");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL R2: watchdog expired, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule